// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block maps a physical page number, counted in 4 KiB pages, onto one of eight memory chip-select rows. Software programs eight cumulative row-top registers. Each one holds the total amount of memory from row 0 up to and including its own row. The last register therefore gives the total installed memory. Software also programs one 32-bit attribute word that carries a 2-bit device-width code for every row. The size of one boundary step depends on the channel configuration: 64 MiB (2^14 pages) with one channel and 128 MiB (2^15 pages) with two.

A lookup is a single-cycle strobe with a page number. One clock later the block returns a registered result with a valid pulse. The result gives a hit/miss flag, the row index, the width code of that row and the error-correction mode that applies to it. A row whose top equals the top of the row before it holds no memory and never matches. A flag reverses the reported row numbering so that boards with the opposite chip-select order read correctly.

Top module: `rbd_decoder`

## Requirements
- R1: After reset every row-top register and the attribute word are zero. Every lookup then misses.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While no request is made, `rsp_hit`, `rsp_row`, `rsp_width` and `rsp_ecc` hold their values.
- R3: Row i matches when lo_i*U <= page < top_i*U. Here top_i is the row-top register of row i, lo_i is top_(i-1), lo_0 is 0, and U is the step size in pages. If several rows match, the lowest row wins.
- R4: U is 2^14 pages when `dual_chan` is 0 and 2^15 pages when `dual_chan` is 1. The values of `dual_chan`, `ecc_en` and `map_rev` are sampled in the request cycle.
- R5: A row whose top equals its lower bound holds no memory and never matches, whatever the page.
- R6: A page that matches no row reports `rsp_hit`=0, `rsp_row`=all ones, `rsp_width`=0 and `rsp_ecc`=0. `map_rev` does not change this.
- R7: On a hit, `rsp_width` is bits [4*i+3:4*i+2] of the attribute word for the matched row i. Code 2 means x4 devices; any other code means x8.
- R8: `rsp_ecc` encodes 0 = none, 1 = single-error-correct/double-error-detect, 2 = 4-bit symbol correction. On a hit with `ecc_en`=1, code 2 is reported when `dual_chan`=1 and the width code is 2; otherwise code 1 is reported. With `ecc_en`=0 the code is 0.
- R9: On a hit with `map_rev`=1, `rsp_row` is 7 minus the matched row. With `map_rev`=0 it is the matched row itself.
- R10: A write with `wr_sel` = i (0..7) loads `wr_data[7:0]` into row-top register i. A write with `wr_sel` = 8 loads all of `wr_data` into the attribute word. A lookup in the same cycle as a write uses the values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Target of write: 0..7 row tops, 8 attribute word |
| wr_data | input | 32 | Write data |
| dual_chan | input | 1 | 1 = two channels (128 MiB step) |
| ecc_en | input | 1 | Error correction enabled |
| map_rev | input | 1 | Report rows in reversed order |
| req_valid | input | 1 | Lookup request strobe |
| req_page | input | 24 | Page number (4 KiB units) |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_hit | output | 1 | Page lies in a populated row |
| rsp_row | output | 3 | Row index, all ones on a miss |
| rsp_width | output | 2 | Device width code of the row |
| rsp_ecc | output | 2 | Error-correction mode of the row |

## Verification
The hardest situations to reach from the ports are pages that sit exactly on a step edge next to an empty row. A page one below the step must land in the lower row. The page on the step must skip every empty row and land in the next populated one. The same edges must also move when the channel mode doubles the step. The directed part of the stimulus programs a layout with several empty rows and probes both sides of each edge in both channel modes. The random part then writes layouts whose tops repeat often, so that runs of empty rows appear, and draws pages both near the steps and beyond the last top.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [1:0] {
    ECC_NONE   = 2'd0,
    ECC_SECDED = 2'd1,
    ECC_SYM4   = 2'd2
  } ecc_mode_e;

  localparam logic [1:0] WCODE_X4 = 2'd2;
endpackage

// File: rtl/rbd_cfg_regs.sv
module rbd_cfg_regs #(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int ATTR_W   = 32,
  parameter int SEL_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [ATTR_W-1:0]         wr_data,
  output logic [NUM_ROWS*BND_W-1:0] bnd_flat,
  output logic [ATTR_W-1:0]         attr
);
  // one enabled register per row top
  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_top
    logic             ld;
    logic [BND_W-1:0] top_q;
    logic [BND_W-1:0] top_d;

    always_comb begin
      ld    = wr_en && (wr_sel == SEL_W'(i));
      top_d = ld ? wr_data[BND_W-1:0] : top_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) top_q <= '0;
      else        top_q <= top_d;
    end

    assign bnd_flat[i*BND_W +: BND_W] = top_q;
  end

  logic              attr_ld;
  logic [ATTR_W-1:0] attr_d;

  always_comb begin
    attr_ld = wr_en && (wr_sel == SEL_W'(NUM_ROWS));
    attr_d  = attr_ld ? wr_data : attr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) attr <= '0;
    else        attr <= attr_d;
  end
endmodule

// File: rtl/rbd_row_match.sv
module rbd_row_match #(
  parameter int NUM_ROWS     = 8,
  parameter int BND_W        = 8,
  parameter int PAGE_W       = 24,
  parameter int SHIFT_SINGLE = 14
) (
  input  logic [NUM_ROWS*BND_W-1:0] bnd_flat,
  input  logic                      dual_chan,
  input  logic [PAGE_W-1:0]         page,
  output logic [NUM_ROWS-1:0]       hit_vec
);
  localparam int EXT_W = PAGE_W + 2;

  logic [EXT_W-1:0] page_ext;
  assign page_ext = EXT_W'(page);

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic [BND_W-1:0] top_raw;
    logic [BND_W-1:0] lo_raw;
    logic [EXT_W-1:0] top_pg;
    logic [EXT_W-1:0] lo_pg;

    assign top_raw = bnd_flat[i*BND_W +: BND_W];
    if (i == 0) begin : g_first
      assign lo_raw = '0;
    end else begin : g_rest
      assign lo_raw = bnd_flat[(i-1)*BND_W +: BND_W];
    end

    always_comb begin
      top_pg = dual_chan ? (EXT_W'(top_raw) << (SHIFT_SINGLE + 1))
                         : (EXT_W'(top_raw) << SHIFT_SINGLE);
      lo_pg  = dual_chan ? (EXT_W'(lo_raw) << (SHIFT_SINGLE + 1))
                         : (EXT_W'(lo_raw) << SHIFT_SINGLE);
      hit_vec[i] = (top_raw != lo_raw) && (page_ext >= lo_pg) &&
                   (page_ext < top_pg);
    end
  end
endmodule

// File: rtl/rbd_result.sv
module rbd_result
  import rbd_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int ATTR_W   = 32,
  parameter int ROW_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [NUM_ROWS-1:0] hit_vec,
  input  logic [ATTR_W-1:0]   attr,
  input  logic                dual_chan,
  input  logic                ecc_en,
  input  logic                map_rev,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [ROW_W-1:0]    rsp_row,
  output logic [1:0]          rsp_width,
  output logic [1:0]          rsp_ecc
);
  logic [ROW_W-1:0] idx;
  logic             any_hit;
  logic [1:0]       wcode;
  ecc_mode_e        ecc_d;
  logic [ROW_W-1:0] row_d;
  logic             hit_d;
  logic [1:0]       width_d;
  logic             valid_d;

  // lowest matching row wins
  always_comb begin
    idx     = '0;
    any_hit = |hit_vec;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = ROW_W'(i);
    end
    wcode = attr[4*idx + 2 +: 2];
    if (!any_hit || !ecc_en)                ecc_d = ECC_NONE;
    else if (dual_chan && wcode == WCODE_X4) ecc_d = ECC_SYM4;
    else                                    ecc_d = ECC_SECDED;
    if (!any_hit)     row_d = '1;
    else if (map_rev) row_d = ROW_W'(NUM_ROWS - 1) - idx;
    else              row_d = idx;
    hit_d   = any_hit;
    width_d = any_hit ? wcode : 2'd0;
    valid_d = req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_row   <= '1;
      rsp_width <= 2'd0;
      rsp_ecc   <= 2'd0;
    end else begin
      rsp_valid <= valid_d;
      if (req_valid) begin
        rsp_hit   <= hit_d;
        rsp_row   <= row_d;
        rsp_width <= width_d;
        rsp_ecc   <= ecc_d;
      end
    end
  end
endmodule

// File: rtl/rbd_decoder.sv
module rbd_decoder #(
  parameter int NUM_ROWS     = 8,
  parameter int BND_W        = 8,
  parameter int PAGE_W       = 24,
  parameter int SHIFT_SINGLE = 14
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [$clog2(NUM_ROWS+1)-1:0]     wr_sel,
  input  logic [4*NUM_ROWS-1:0]             wr_data,
  input  logic                              dual_chan,
  input  logic                              ecc_en,
  input  logic                              map_rev,
  input  logic                              req_valid,
  input  logic [PAGE_W-1:0]                 req_page,
  output logic                              rsp_valid,
  output logic                              rsp_hit,
  output logic [$clog2(NUM_ROWS)-1:0]       rsp_row,
  output logic [1:0]                        rsp_width,
  output logic [1:0]                        rsp_ecc
);
  localparam int ATTR_W = 4 * NUM_ROWS;
  localparam int SEL_W  = $clog2(NUM_ROWS + 1);
  localparam int ROW_W  = $clog2(NUM_ROWS);

  // reset asserts at once, releases on a clock edge
  logic rst_meta_n;
  logic rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic [NUM_ROWS*BND_W-1:0] bnd_flat;
  logic [ATTR_W-1:0]         attr;
  logic [NUM_ROWS-1:0]       hit_vec;

  rbd_cfg_regs #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .ATTR_W(ATTR_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .bnd_flat(bnd_flat), .attr(attr)
  );

  rbd_row_match #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .PAGE_W(PAGE_W),
    .SHIFT_SINGLE(SHIFT_SINGLE)
  ) u_match (
    .bnd_flat(bnd_flat), .dual_chan(dual_chan), .page(req_page),
    .hit_vec(hit_vec)
  );

  rbd_result #(
    .NUM_ROWS(NUM_ROWS), .ATTR_W(ATTR_W), .ROW_W(ROW_W)
  ) u_res (
    .clk(clk), .rst_n(rst_q_n), .req_valid(req_valid), .hit_vec(hit_vec),
    .attr(attr), .dual_chan(dual_chan), .ecc_en(ecc_en), .map_rev(map_rev),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_row(rsp_row),
    .rsp_width(rsp_width), .rsp_ecc(rsp_ecc)
  );
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
  parameter int ROW_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             ecc_en,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [ROW_W-1:0] rsp_row,
  input logic [1:0]       rsp_width,
  input logic [1:0]       rsp_ecc
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_hit) && $stable(rsp_row) &&
                    $stable(rsp_width) && $stable(rsp_ecc)));
  // R6
  miss_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_row == '1 && rsp_width == 2'd0 &&
                                 rsp_ecc == 2'd0));
  // R8
  sym4_needs_x4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ecc == 2'd2) |-> (rsp_width == 2'd2));
  // R8
  ecc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ecc_en) |=> (rsp_ecc == 2'd0));
  // R8
  ecc_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ecc != 2'd3));
endmodule

bind rbd_decoder rbd_checker #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .req_valid(req_valid), .ecc_en(ecc_en),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_row(rsp_row),
  .rsp_width(rsp_width), .rsp_ecc(rsp_ecc)
);

// File: tb/test_rbd_decoder.sv
module test_rbd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        dual_chan = 1'b0, ecc_en = 1'b0, map_rev = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_page = '0;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_row;
  logic [1:0]  rsp_width, rsp_ecc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int top_m[8];
  logic [31:0] attr_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  rbd_decoder i_rbd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .dual_chan(dual_chan), .ecc_en(ecc_en),
    .map_rev(map_rev), .req_valid(req_valid), .req_page(req_page),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_row(rsp_row),
    .rsp_width(rsp_width), .rsp_ecc(rsp_ecc)
  );

  function automatic void model(input int page, input bit dual, input bit ecc,
                                input bit rev, output bit hit,
                                output logic [2:0] row, output logic [1:0] w,
                                output logic [1:0] e);
    int sh = dual ? SH + 1 : SH;
    int lo;
    int found = -1;
    for (int i = 7; i >= 0; i--) begin
      lo = (i == 0) ? 0 : top_m[i-1];
      if (top_m[i] != lo && page >= (lo << sh) && page < (top_m[i] << sh))
        found = i;
    end
    hit = (found >= 0);
    if (!hit) begin
      row = 3'b111; w = 2'd0; e = 2'd0;
    end else begin
      w   = attr_m[4*found + 2 +: 2];
      row = rev ? 3'(7 - found) : 3'(found);
      e   = !ecc ? 2'd0 : ((dual && w == 2'd2) ? 2'd2 : 2'd1);
    end
  endfunction

  task automatic chk(input string tag, input bit ok, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel < 8) top_m[sel] = int'(d[7:0]);
    else attr_m = d;
  endtask

  task automatic lookup(input string tag, input int page, input bit dual,
                        input bit ecc, input bit rev);
    bit h; logic [2:0] r; logic [1:0] w, e;
    model(page, dual, ecc, rev, h, r, w, e);
    @(negedge clk);
    req_valid = 1'b1; req_page = 24'(page);
    dual_chan = dual; ecc_en = ecc; map_rev = rev;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, rsp_valid == 1'b1, "valid", int'(rsp_valid), 1);
    chk(tag, rsp_hit == h, "hit", int'(rsp_hit), int'(h));
    chk(tag, rsp_row == r, "row", int'(rsp_row), int'(r));
    chk(tag, rsp_width == w, "width", int'(rsp_width), int'(w));
    chk(tag, rsp_ecc == e, "ecc", int'(rsp_ecc), int'(e));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0]  hold_row;
    logic        hold_hit;
    int          tops[8];
    for (int i = 0; i < 8; i++) top_m[i] = 0;
    attr_m = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and misses with empty layout
    chk("R1", rsp_valid == 1'b0, "valid after reset", int'(rsp_valid), 0);
    lookup("R1", 0, 1'b0, 1'b1, 1'b0);
    lookup("R1", 100, 1'b1, 1'b1, 1'b1);

    // R10 program layout with empty rows 1,3,6
    tops = '{2, 2, 5, 5, 9, 12, 12, 20};
    for (int i = 0; i < 8; i++) wr(i, 32'(tops[i]) | 32'hFF00);
    wr(8, 32'h80C8_0804);

    // R3 edges, single channel
    lookup("R3", (2 << SH) - 1, 1'b0, 1'b1, 1'b0);
    lookup("R3", 0, 1'b0, 1'b1, 1'b0);
    // R5 step lands past empty row 1 into row 2
    lookup("R5", 2 << SH, 1'b0, 1'b1, 1'b0);
    lookup("R5", 5 << SH, 1'b0, 1'b1, 1'b0);
    lookup("R5", 12 << SH, 1'b0, 1'b1, 1'b0);
    lookup("R7", (9 << SH) + 7, 1'b0, 1'b1, 1'b0);
    // R6 above last top
    lookup("R6", (20 << SH) - 1, 1'b0, 1'b1, 1'b0);
    lookup("R6", 20 << SH, 1'b0, 1'b1, 1'b1);
    // R4 dual step doubles
    lookup("R4", 20 << SH, 1'b1, 1'b1, 1'b0);
    lookup("R4", (20 << (SH+1)) - 1, 1'b1, 1'b1, 1'b0);
    lookup("R4", 20 << (SH+1), 1'b1, 1'b1, 1'b0);
    // R8 modes
    lookup("R8", 3 << (SH+1), 1'b1, 1'b1, 1'b0);
    lookup("R8", 3 << SH, 1'b0, 1'b1, 1'b0);
    lookup("R8", 3 << (SH+1), 1'b1, 1'b0, 1'b0);
    lookup("R8", 10 << (SH+1), 1'b1, 1'b1, 1'b0);
    // R9 reversed order
    lookup("R9", 1, 1'b0, 1'b1, 1'b1);
    lookup("R9", 6 << SH, 1'b0, 1'b0, 1'b1);

    // R2 outputs hold while idle
    hold_row = rsp_row; hold_hit = rsp_hit;
    @(negedge clk);
    chk("R2", rsp_valid == 1'b0, "valid idle", int'(rsp_valid), 0);
    chk("R2", rsp_row == hold_row, "row held", int'(rsp_row), int'(hold_row));
    chk("R2", rsp_hit == hold_hit, "hit held", int'(rsp_hit), int'(hold_hit));

    // R10 lookup in same cycle as a write sees old value
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd0; wr_data = 32'd0;
    req_valid = 1'b1; req_page = 24'd1; dual_chan = 1'b0; map_rev = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0; top_m[0] = 0;
    chk("R10", rsp_hit == 1'b1, "old top used", int'(rsp_hit), 1);
    chk("R10", rsp_row == 3'd0, "old row", int'(rsp_row), 0);
    lookup("R10", 1, 1'b0, 1'b1, 1'b0);

    // random layouts and lookups (R3 R5 R7 R8 R9)
    for (int n = 0; n < 40; n++) begin
      int acc = 0;
      for (int i = 0; i < 8; i++) begin
        if ($urandom_range(0, 2) != 0) acc = acc + int'($urandom_range(1, 31));
        if (acc > 255) acc = 255;
        wr(i, 32'(acc));
      end
      wr(8, $urandom);
      for (int k = 0; k < 20; k++) begin
        bit dl = 1'($urandom);
        int sh = dl ? SH + 1 : SH;
        int pg;
        int r = int'($urandom_range(0, 7));
        case ($urandom_range(0, 2))
          0: pg = top_m[r] << sh;
          1: pg = (top_m[r] << sh) - 1;
          default: pg = int'($urandom_range(0, (top_m[7] + 2) << sh));
        endcase
        if (pg < 0) pg = 0;
        lookup("R3", pg, dl, 1'($urandom), 1'($urandom));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule